// File: doc/BRIEF.md
# Scan pattern application sequencer

This block sits on the tester side of a scan-chain device under test and plays a set of stored patterns into it. For every pattern it shifts the stimulus into the chain with the device in test mode. It then drops to functional mode, compares the primary outputs, drives the primary inputs and gives exactly one capture clock. It goes back to test mode, strobes the first scan-out bit before any shift clock, and shifts again. The shift cycles that unload one pattern's captured response also load the next pattern's stimulus. After the last capture, one extra unload-only pass empties the chain.

Patterns are written into a small internal memory through a simple write port. Each pattern holds its stimulus, its primary-input values, and the expected values with per-bit compare masks for the primary outputs and the scan response. Mismatches set a sticky fail flag. The pattern number and bit number of the first mismatch are kept, and a one-cycle done pulse ends the run. The device clock is modelled as a one-cycle enable (`dut_clk`), and the device acts on it at the next rising edge of `clk`.

Top module: `scan_pattern_sequencer`

## Requirements
- R1: After reset the block is idle with `scan_en`=1, `dut_clk`=0, `scan_in`=0, `pi_out`=0, `done`=0 and `fail`=0.
- R2: On an accepted `start` the block gives CHAIN_LEN shift cycles with `scan_en`=1 and `dut_clk`=1. It sends stimulus bit CHAIN_LEN-1 first and bit 0 last, so stimulus bit i ends in flop i. Flop 0 takes `scan_in` and flop CHAIN_LEN-1 drives `scan_out`.
- R3: After each load come three cycles with `scan_en`=0. The first is a primary-output compare cycle with no clock and `pi_out`=0. The second drives the pattern's primary inputs with no clock. The third gives exactly one `dut_clk` with the same primary inputs held.
- R4: The cycle after the capture clock has `scan_en`=1 and no clock, and compares `scan_out` against response bit 0 before any shift clock.
- R5: The next CHAIN_LEN shift cycles load the next pattern's stimulus and unload the previous response. Shift cycle k (k from 1 to CHAIN_LEN-1) compares `scan_out` with response bit k. Response bit j is the j-th bit seen at `scan_out`, which is the value captured in flop CHAIN_LEN-1-j.
- R6: After the last pattern's capture, the strobe and unload pass drive `scan_in`=0. The cycle after the last shift raises `done` for exactly one cycle with `scan_en`=1 and no clock, and then the block is idle.
- R7: A mask bit of 1 enables the compare of that bit and a 0 ignores it, for both primary outputs and scan response.
- R8: The first mismatch sets `fail`, which stays set until the next accepted `start`. `fail_pat` holds that pattern's index. `fail_po`=1 for a primary-output mismatch, and then `fail_bit` is the lowest mismatching output bit. `fail_po`=0 for a scan mismatch, and then `fail_bit` is the response bit index. Later mismatches do not change the record.
- R9: `start` is ignored while a run is in progress. `num_pat` is sampled when `start` is accepted, and an accepted `start` clears the fail record.
- R10: Patterns are written at address `wr_addr` when `wr_en`=1. With `num_pat`=0, an accepted `start` gives `done` in the next cycle with no clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tester clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pattern memory write strobe |
| wr_addr | input | PAW | Pattern index to write |
| wr_stim | input | CHAIN_LEN | Scan stimulus, bit i for flop i |
| wr_pi | input | NUM_PI | Primary input values for capture |
| wr_po_exp | input | NUM_PO | Expected primary outputs |
| wr_po_mask | input | NUM_PO | Primary output compare enables |
| wr_so_exp | input | CHAIN_LEN | Expected response, bit j is j-th bit out |
| wr_so_mask | input | CHAIN_LEN | Response compare enables |
| num_pat | input | PAW+1 | Number of patterns to apply |
| start | input | 1 | Start request, accepted when idle |
| scan_en | output | 1 | 1 = test (shift) mode, 0 = functional mode |
| scan_in | output | 1 | Serial data into flop 0 |
| dut_clk | output | 1 | One device clock edge per cycle it is high |
| pi_out | output | NUM_PI | Primary inputs driven to the device |
| scan_out | input | 1 | Serial data from the last flop |
| po_in | input | NUM_PO | Primary outputs from the device |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_po | output | 1 | First mismatch was on primary outputs |
| fail_pat | output | PAW | Pattern index of first mismatch |
| fail_bit | output | BW | Bit index of first mismatch |

## Verification
Every drive output is decoded from the state register, so each step of the sequence appears in the cycle right after the rising edge that entered it. The bench builds the full expected cycle list for a run (load, output compare, input apply, capture, strobe, overlapped shift, done) from the requirements and compares it with the outputs at every falling edge, starting one cycle after `start`. The fail record is written at the edge that ends the compare cycle, so the bench reads it only after the done pulse, against a first mismatch found by walking its own model in time order: outputs of pattern p, then response bits 0 to CHAIN_LEN-1 of pattern p.

// File: rtl/scan_pattern_sequencer.sv
module scan_pattern_sequencer #(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_PI    = 4,
  parameter int NUM_PO    = 4,
  parameter int MAX_PAT   = 8,
  localparam int PAW = (MAX_PAT > 1) ? $clog2(MAX_PAT) : 1,
  localparam int CW  = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int BW  = (CHAIN_LEN > NUM_PO) ? CW : ((NUM_PO > 1) ? $clog2(NUM_PO) : 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PAW-1:0]       wr_addr,
  input  logic [CHAIN_LEN-1:0] wr_stim,
  input  logic [NUM_PI-1:0]    wr_pi,
  input  logic [NUM_PO-1:0]    wr_po_exp,
  input  logic [NUM_PO-1:0]    wr_po_mask,
  input  logic [CHAIN_LEN-1:0] wr_so_exp,
  input  logic [CHAIN_LEN-1:0] wr_so_mask,
  input  logic [PAW:0]         num_pat,
  input  logic                 start,
  output logic                 scan_en,
  output logic                 scan_in,
  output logic                 dut_clk,
  output logic [NUM_PI-1:0]    pi_out,
  input  logic                 scan_out,
  input  logic [NUM_PO-1:0]    po_in,
  output logic                 done,
  output logic                 fail,
  output logic                 fail_po,
  output logic [PAW-1:0]       fail_pat,
  output logic [BW-1:0]        fail_bit
);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_PO, S_PI, S_CAP, S_STROBE, S_DONE} state_t;

  localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

  logic [CHAIN_LEN-1:0] stim_mem  [MAX_PAT];
  logic [NUM_PI-1:0]    pi_mem    [MAX_PAT];
  logic [NUM_PO-1:0]    poe_mem   [MAX_PAT];
  logic [NUM_PO-1:0]    pom_mem   [MAX_PAT];
  logic [CHAIN_LEN-1:0] soe_mem   [MAX_PAT];
  logic [CHAIN_LEN-1:0] som_mem   [MAX_PAT];

  state_t          state;
  logic [PAW:0]    np;
  logic [PAW:0]    ld_idx;
  logic            have_unl;
  logic [CW-1:0]   cnt;

  logic [PAW-1:0]  ld_a, un_a;
  logic            ld_v;
  logic [CW-1:0]   so_idx;
  logic            so_cmp, so_bad, po_bad;
  logic [NUM_PO-1:0] po_err;
  logic [BW-1:0]   po_low;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      stim_mem[wr_addr] <= wr_stim;
      pi_mem[wr_addr]   <= wr_pi;
      poe_mem[wr_addr]  <= wr_po_exp;
      pom_mem[wr_addr]  <= wr_po_mask;
      soe_mem[wr_addr]  <= wr_so_exp;
      som_mem[wr_addr]  <= wr_so_mask;
    end
  end

  assign ld_a = ld_idx[PAW-1:0];
  assign un_a = PAW'(ld_idx - 1'b1);
  assign ld_v = ld_idx < np;

  assign scan_en = !(state == S_PO || state == S_PI || state == S_CAP);
  assign dut_clk = (state == S_SHIFT) || (state == S_CAP);
  assign scan_in = (state == S_SHIFT && ld_v) ? stim_mem[ld_a][LAST - cnt] : 1'b0;
  assign pi_out  = (state == S_PI || state == S_CAP) ? pi_mem[ld_a] : '0;
  assign done    = (state == S_DONE);

  assign so_idx = (state == S_STROBE) ? '0 : cnt;
  assign so_cmp = (state == S_STROBE) || (state == S_SHIFT && have_unl && cnt != '0);
  assign so_bad = so_cmp && som_mem[un_a][so_idx] && (scan_out != soe_mem[un_a][so_idx]);
  assign po_err = (po_in ^ poe_mem[ld_a]) & pom_mem[ld_a];
  assign po_bad = (state == S_PO) && (|po_err);

  always_comb begin
    po_low = '0;
    for (int i = NUM_PO - 1; i >= 0; i--)
      if (po_err[i]) po_low = BW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      np       <= '0;
      ld_idx   <= '0;
      have_unl <= 1'b0;
      cnt      <= '0;
      fail     <= 1'b0;
      fail_po  <= 1'b0;
      fail_pat <= '0;
      fail_bit <= '0;
    end else begin
      if (!fail && po_bad) begin
        fail     <= 1'b1;
        fail_po  <= 1'b1;
        fail_pat <= ld_a;
        fail_bit <= po_low;
      end else if (!fail && so_bad) begin
        fail     <= 1'b1;
        fail_po  <= 1'b0;
        fail_pat <= un_a;
        fail_bit <= BW'(so_idx);
      end
      case (state)
        S_IDLE: if (start) begin
          np       <= num_pat;
          ld_idx   <= '0;
          have_unl <= 1'b0;
          cnt      <= '0;
          fail     <= 1'b0;
          fail_po  <= 1'b0;
          fail_pat <= '0;
          fail_bit <= '0;
          state    <= (num_pat == '0) ? S_DONE : S_SHIFT;
        end
        S_SHIFT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ld_v ? S_PO : S_DONE;
          end
        end
        S_PO:  state <= S_PI;
        S_PI:  state <= S_CAP;
        S_CAP: begin
          ld_idx   <= ld_idx + 1'b1;
          have_unl <= 1'b1;
          state    <= S_STROBE;
        end
        S_STROBE: state <= S_SHIFT;
        S_DONE:   state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  AST_CAPTURE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (dut_clk && !scan_en) |=> (scan_en && !dut_clk)); // R4
  AST_PO_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |-> (!dut_clk && pi_out == '0)); // R3
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

// File: tb/scan_pattern_sequencer_tb.sv
`timescale 1ns/1ps
module scan_pattern_sequencer_tb;
  localparam int L = 8, NPI = 4, NPO = 4, MP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic wr_en = 0, start = 0;
  logic [2:0] wr_addr = '0;
  logic [L-1:0] wr_stim = '0, wr_so_exp = '0, wr_so_mask = '0;
  logic [NPI-1:0] wr_pi = '0;
  logic [NPO-1:0] wr_po_exp = '0, wr_po_mask = '0;
  logic [3:0] num_pat = '0;
  logic scan_en, scan_in, dut_clk, done, fail, fail_po, scan_out;
  logic [NPI-1:0] pi_out;
  logic [NPO-1:0] po_in;
  logic [2:0] fail_pat, fail_bit;

  scan_pattern_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_stim(wr_stim),
    .wr_pi(wr_pi), .wr_po_exp(wr_po_exp), .wr_po_mask(wr_po_mask), .wr_so_exp(wr_so_exp),
    .wr_so_mask(wr_so_mask), .num_pat(num_pat), .start(start), .scan_en(scan_en),
    .scan_in(scan_in), .dut_clk(dut_clk), .pi_out(pi_out), .scan_out(scan_out),
    .po_in(po_in), .done(done), .fail(fail), .fail_po(fail_po), .fail_pat(fail_pat),
    .fail_bit(fail_bit));

  function automatic logic [L-1:0] capf(logic [L-1:0] c, logic [NPI-1:0] p);
    for (int i = 0; i < L; i++) capf[i] = c[(i+1)%L] ^ (c[i] & p[i%NPI]) ^ p[(i+1)%NPI];
  endfunction
  function automatic logic [NPO-1:0] pof(logic [L-1:0] c);
    for (int i = 0; i < NPO; i++) pof[i] = c[2*i] ^ c[2*i+1];
  endfunction

  // device under test model: flop 0 takes scan_in, flop L-1 drives scan_out
  logic [L-1:0] chain = '0;
  always @(posedge clk) if (dut_clk) chain <= scan_en ? {chain[L-2:0], scan_in} : capf(chain, pi_out);
  assign scan_out = chain[L-1];
  assign po_in = pof(chain);

  int checks = 0, fails = 0;
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [L-1:0] s_stim [MP], s_soe [MP], s_som [MP];
  logic [NPI-1:0] s_pi [MP];
  logic [NPO-1:0] s_poe [MP], s_pom [MP];

  task automatic set_pat(int p, logic [L-1:0] st, logic [NPI-1:0] pi);
    logic [L-1:0] cap;
    s_stim[p] = st; s_pi[p] = pi;
    s_poe[p] = pof(st); s_pom[p] = '1;
    cap = capf(st, pi);
    for (int j = 0; j < L; j++) s_soe[p][j] = cap[L-1-j];
    s_som[p] = '1;
  endtask

  logic [7:0] eq[$];
  string tq[$];
  task automatic push(bit d, bit se, bit ck, bit si, logic [3:0] pi, string tag);
    eq.push_back({d, se, ck, si, pi});
    tq.push_back(tag);
  endtask

  task automatic run(int n, bit extra_start);
    bit ef, epo; int epat, ebit; logic [L-1:0] cap; logic [NPO-1:0] pe; int cyc;
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = 3'(p); wr_stim = s_stim[p]; wr_pi = s_pi[p];
      wr_po_exp = s_poe[p]; wr_po_mask = s_pom[p]; wr_so_exp = s_soe[p]; wr_so_mask = s_som[p];
    end
    @(negedge clk); wr_en = 0;
    eq.delete(); tq.delete();
    if (n > 0) for (int k = 0; k < L; k++) push(0, 1, 1, s_stim[0][L-1-k], 0, "R2");
    for (int p = 0; p < n; p++) begin
      push(0, 0, 0, 0, 0, "R3");
      push(0, 0, 0, 0, s_pi[p], "R3");
      push(0, 0, 1, 0, s_pi[p], "R3");
      push(0, 1, 0, 0, 0, "R4");
      for (int k = 0; k < L; k++)
        push(0, 1, 1, (p + 1 < n) ? s_stim[p+1][L-1-k] : 1'b0, 0, (p + 1 < n) ? "R5" : "R6");
    end
    push(1, 1, 0, 0, 0, (n == 0) ? "R10" : "R6");
    push(0, 1, 0, 0, 0, "R6");
    ef = 0; epo = 0; epat = 0; ebit = 0;
    for (int p = 0; p < n && !ef; p++) begin
      pe = (pof(s_stim[p]) ^ s_poe[p]) & s_pom[p];
      for (int i = NPO - 1; i >= 0; i--) if (pe[i]) begin ef = 1; epo = 1; epat = p; ebit = i; end
      if (!ef) begin
        cap = capf(s_stim[p], s_pi[p]);
        for (int j = 0; j < L && !ef; j++)
          if (s_som[p][j] && cap[L-1-j] != s_soe[p][j]) begin ef = 1; epat = p; ebit = j; end
      end
    end
    num_pat = 4'(n); start = 1;
    cyc = 0;
    while (eq.size() > 0) begin
      @(negedge clk);
      start = (extra_start && cyc == 4);
      check(tq.pop_front(), {24'd0, eq.pop_front()}, {24'd0, done, scan_en, dut_clk, scan_in, pi_out});
      cyc++;
    end
    start = 0;
    check("R8 fail flag", {31'd0, fail}, {31'd0, ef});
    if (ef) begin
      check("R8 fail_po", {31'd0, fail_po}, {31'd0, epo});
      check("R8 fail_pat", {29'd0, fail_pat}, 32'(epat));
      check("R8 fail_bit", {29'd0, fail_bit}, 32'(ebit));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle outputs", {27'd0, done, scan_en, dut_clk, scan_in, fail},
          {27'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
    check("R1 pi_out", {28'd0, pi_out}, 32'd0);

    for (int p = 0; p < MP; p++) set_pat(p, 8'(p * 37 + 5), 4'(p * 3 + 1));
    run(3, 0);                                             // R2 R3 R4 R5 R6 clean

    for (int p = 0; p < MP; p++) set_pat(p, 8'(p * 91 + 12), 4'(p + 9));
    s_soe[1][3] = ~s_soe[1][3]; s_som[1][3] = 1'b0;          // R7 masked, ignored
    s_soe[2][5] = ~s_soe[2][5];                             // R8 first real mismatch
    s_soe[3][1] = ~s_soe[3][1];                             // R8 later, must not overwrite
    run(4, 0);

    for (int p = 0; p < MP; p++) set_pat(p, 8'(p * 53 + 200), 4'(p * 5));
    s_poe[0][0] = ~s_poe[0][0]; s_pom[0][0] = 1'b0;          // R7 masked output bit
    s_poe[0][2] = ~s_poe[0][2]; s_poe[0][1] = ~s_poe[0][1];  // R8 lowest bit 1
    s_soe[0][4] = ~s_soe[0][4];
    run(3, 0);

    for (int p = 0; p < MP; p++) set_pat(p, 8'(p * 29 + 77), 4'(15 - p));
    s_soe[1][0] = ~s_soe[1][0];                             // R4 strobe bit in final unload
    run(2, 0);

    for (int p = 0; p < MP; p++) set_pat(p, 8'(p * 17 + 3), 4'(p * 7));
    s_soe[0][L-1] = ~s_soe[0][L-1];                          // R5 last bit of unload
    run(1, 0);

    for (int p = 0; p < MP; p++) set_pat(p, 8'(p * 61 + 40), 4'(p + 2));
    run(3, 1);                                              // R9 start ignored, fail cleared
    run(MP, 0);                                             // R10 full memory
    run(0, 0);                                              // R10 empty run

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule